// File: doc/BRIEF.md
# Systolic 3x3 Matrix Multiplier

This block computes C = A x B for two 3x3 matrices of signed 8-bit integers. It uses a square grid of nine identical multiply-accumulate cells. Each cell owns one entry of C and keeps it in place while the sum over k builds up. Operands from A enter on the left edge, one lane per row, and move one cell to the right per clock. Operands from B enter on the top edge, one lane per column, and move one cell down per clock. Every hop between neighbouring cells passes through a register.

A one-cycle start pulse clears all nine accumulators and begins a run of seven accumulation steps. The caller feeds the lanes with a diagonal skew so that matching pairs a[i][k] and b[k][j] meet in cell (i,j) in the same cycle. Each lane accepts data only inside its own three-step window and reads as zero outside it. When the run ends, a done flag rises and the nine results stay on a parallel output bus until the next start.

Top module: `sysmm_top`

## Requirements
- R1: While reset is held and after it is released, with no start yet, `done` is 0 and every result field of `c_flat` is 0.
- R2: A `start` pulse in cycle s clears all nine results and drops `done`. In cycle s+1, `done` is 0 and `c_flat` is all zeros.
- R3: After a run, the result for row i and column j is the sum over k of a[i][k]*b[k][j], with indices 0..2. It sits in `c_flat[(3*i+j)*18 +: 18]` as an 18-bit two's complement value.
- R4: Step t of a run (t = 0..6) is cycle s+1+t. In step t, A lane i (`a_lane[8*i +: 8]`) carries a[i][t-i], and B lane j (`b_lane[8*j +: 8]`) carries b[t-j][j].
- R5: Lane n takes data only in steps n through n+2. A value on that lane in any other step, or while no run is active, has no effect on the results.
- R6: `done` rises in cycle s+8, one cycle after the last product is added into cell (2,2). It stays 0 in cycles s+1 to s+7.
- R7: Once `done` is 1, it and `c_flat` hold unchanged until the next `start`, whatever the lanes carry.
- R8: Extreme operands do not overflow. Full rows of -128 against full columns of -128 give +49152, and -128 against +127 gives -48768.
- R9: A `start` during a run abandons that run. A full fresh run begins and produces only its own result, and `done` rises 8 cycles after the second start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that clears the results and begins a run |
| a_lane | input | 24 | Skewed A operands, one signed byte per row lane |
| b_lane | input | 24 | Skewed B operands, one signed byte per column lane |
| done | output | 1 | Results valid and held |
| c_flat | output | 162 | Nine 18-bit signed results, row-major |

## Verification
The bench drives values on the lanes outside their windows, both during a run and while results are held. A design that does not mask those values adds stray products into the edge cells, or corrupts held results that should be frozen. Operands at the -128 and +127 limits would expose an accumulator that is too narrow or extended without sign as a wrong-signed or wrapped sum. A restart in the middle of a run would catch a design that leaves partial sums in place, or that keeps an old step counter and so raises done at the wrong cycle. Identity and random matrices expose a wrong skew direction, which would transpose or shift the product.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;
  parameter int DATA_W = 8;
  parameter int ACC_W  = 18;
  parameter int DIM    = 3;
endpackage

// File: rtl/sysmm_ctrl.sv
module sysmm_ctrl #(
  parameter int DIM = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           clr,
  output logic           acc_en,
  output logic [DIM-1:0] lane_ok,
  output logic           done
);
  localparam int STEPS = 3 * DIM - 2;
  localparam int SW    = $clog2(STEPS + 1);

  logic          busy_q, busy_n;
  logic          done_q, done_n;
  logic [SW-1:0] step_q, step_n;

  always_comb begin
    busy_n = busy_q;
    done_n = done_q;
    step_n = step_q;
    if (start) begin
      busy_n = 1'b1;
      done_n = 1'b0;
      step_n = '0;
    end else if (busy_q) begin
      if (step_q == SW'(STEPS - 1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        step_n = '0;
      end else begin
        step_n = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      step_q <= step_n;
    end
  end

  for (genvar n = 0; n < DIM; n++) begin : g_win
    assign lane_ok[n] = busy_q && (int'(step_q) >= n) && (int'(step_q) <= n + DIM - 1);
  end

  assign clr    = start;
  assign acc_en = busy_q && !start;
  assign done   = done_q;
endmodule

// File: rtl/sysmm_pe.sv
module sysmm_pe #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 18,
  parameter bit PASS_A = 1'b1,
  parameter bit PASS_B = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     acc_en,
  input  logic signed [DATA_W-1:0] a_in,
  input  logic signed [DATA_W-1:0] b_in,
  output logic signed [DATA_W-1:0] a_out,
  output logic signed [DATA_W-1:0] b_out,
  output logic signed [ACC_W-1:0]  acc
);
  localparam int PW = 2 * DATA_W;

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] acc_q, acc_n;

  assign prod = a_in * b_in;

  always_comb begin
    acc_n = acc_q;
    if (clr)
      acc_n = '0;
    else if (acc_en)
      acc_n = acc_q + {{(ACC_W-PW){prod[PW-1]}}, prod};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end

  if (PASS_A) begin : g_a
    logic signed [DATA_W-1:0] a_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) a_q <= '0;
      else        a_q <= clr ? '0 : a_in;
    end
    assign a_out = a_q;
  end else begin : g_na
    assign a_out = '0;
  end

  if (PASS_B) begin : g_b
    logic signed [DATA_W-1:0] b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) b_q <= '0;
      else        b_q <= clr ? '0 : b_in;
    end
    assign b_out = b_q;
  end else begin : g_nb
    assign b_out = '0;
  end

  assign acc = acc_q;
endmodule

// File: rtl/sysmm_top.sv
module sysmm_top
  import sysmm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ACC_W,
  parameter int N  = DIM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N*DW-1:0]   a_lane,
  input  logic [N*DW-1:0]   b_lane,
  output logic              done,
  output logic [N*N*AW-1:0] c_flat
);
  logic         clr, acc_en;
  logic [N-1:0] lane_ok;

  logic signed [DW-1:0] a_lnk [N][N+1];
  logic signed [DW-1:0] b_lnk [N+1][N];
  logic signed [AW-1:0] acc   [N][N];

  sysmm_ctrl #(.DIM(N)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .clr    (clr),
    .acc_en (acc_en),
    .lane_ok(lane_ok),
    .done   (done)
  );

  for (genvar n = 0; n < N; n++) begin : g_edge
    assign a_lnk[n][0] = lane_ok[n] ? $signed(a_lane[n*DW +: DW]) : '0;
    assign b_lnk[0][n] = lane_ok[n] ? $signed(b_lane[n*DW +: DW]) : '0;
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      sysmm_pe #(
        .DATA_W(DW),
        .ACC_W (AW),
        .PASS_A(j < N - 1),
        .PASS_B(i < N - 1)
      ) u_pe (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .acc_en(acc_en),
        .a_in  (a_lnk[i][j]),
        .b_in  (b_lnk[i][j]),
        .a_out (a_lnk[i][j+1]),
        .b_out (b_lnk[i+1][j]),
        .acc   (acc[i][j])
      );
      assign c_flat[(i*N+j)*AW +: AW] = acc[i][j];
    end
  end
endmodule

// File: rtl/sysmm_chk.sv
module sysmm_chk #(
  parameter int N  = 3,
  parameter int AW = 18,
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic [N*N*AW-1:0] c_flat
);
  localparam int LIM = N * (1 << (2*DW - 2));

  logic [3:0] since_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_start <= '0;
    else if (start)
      since_start <= 4'd1;
    else if (since_start != 4'd0 && since_start != 4'd15)
      since_start <= since_start + 4'd1;
  end

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && c_flat == '0));

  assert_done_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> since_start == 4'd8);

  assert_no_early_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_start != 4'd0 && since_start < 4'd8) |-> !done);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(c_flat)));

  for (genvar k = 0; k < N*N; k++) begin : g_rng
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($signed(c_flat[k*AW +: AW]) <= LIM && $signed(c_flat[k*AW +: AW]) >= -LIM));
  end
endmodule

bind sysmm_top sysmm_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .done  (done),
  .c_flat(c_flat)
);

// File: tb/sysmm_top_bench.sv
`timescale 1ns/1ps
module sysmm_top_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [23:0]  a_lane, b_lane;
  logic         done;
  logic [161:0] c_flat;

  int checks = 0, fails = 0, cyc = 0;
  int ma [3][3];
  int mb [3][3];
  int exp_q [$];
  int sc_q  [$];
  bit done_q = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sysmm_top u_sysmm_top (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_lane(a_lane), .b_lane(b_lane), .done(done), .c_flat(c_flat)
  );

  function automatic int res(int k);
    return int'($signed(c_flat[k*18 +: 18]));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: pops the expected result when done rises (R3, R6)
  always @(negedge clk) begin
    if (rst_n && done && !done_q) begin
      if (sc_q.size() == 0) begin
        check(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        automatic int sc = sc_q.pop_front();
        automatic int bad = 0;
        automatic int first_a = 0, first_e = 0;
        check(cyc == sc + 8, "R6", "done cycle", cyc - sc, 8);
        for (int k = 0; k < 9; k++) begin
          automatic int e = exp_q.pop_front();
          if (res(k) != e && bad == 0) begin first_a = res(k); first_e = e; end
          if (res(k) != e) bad++;
        end
        check(bad == 0, "R3", "product entry", first_a, first_e);
      end
    end
    done_q <= done;
  end

  // driver: one run; cut >= 0 abandons after cut steps (R9)
  task automatic run(bit noise, int cut);
    if (cut < 0) begin
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++) begin
          automatic int s = 0;
          for (int k = 0; k < 3; k++) s += ma[i][k] * mb[k][j];
          exp_q.push_back(s);
        end
    end
    @(negedge clk);
    start = 1'b1;
    if (cut < 0) sc_q.push_back(cyc);
    @(negedge clk);
    start = 1'b0;
    check(!done && c_flat == '0, "R2", "cleared after start", int'(done), 0);
    for (int t = 0; t < 7; t++) begin
      if (cut >= 0 && t == cut) return;
      for (int n = 0; n < 3; n++) begin
        if (t - n >= 0 && t - n < 3) begin
          a_lane[n*8 +: 8] = 8'(ma[n][t-n]);
          b_lane[n*8 +: 8] = 8'(mb[t-n][n]);
        end else begin
          a_lane[n*8 +: 8] = noise ? 8'(37 + 13*n + t) : 8'd0;
          b_lane[n*8 +: 8] = noise ? 8'(-91 + 7*n - t) : 8'd0;
        end
      end
      @(negedge clk);
    end
    a_lane = noise ? 24'h5A_C3_7F : '0;
    b_lane = noise ? 24'h81_3C_E5 : '0;
    repeat (3) @(negedge clk);
    a_lane = '0;
    b_lane = '0;
  endtask

  task automatic fill(int sa, int sb);
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) begin
        ma[i][j] = ((sa * 31 + i * 17 + j * 53) % 256) - 128;
        mb[i][j] = ((sb * 29 + i * 71 + j * 11) % 256) - 128;
      end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; a_lane = '0; b_lane = '0;
    repeat (3) @(negedge clk);
    check(!done && c_flat == '0, "R1", "state in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && c_flat == '0, "R1", "state after reset", int'(done), 0);

    // R4: identity times B keeps B in place; a wrong skew shifts it
    for (int i = 0; i < 3; i++) for (int j = 0; j < 3; j++) begin
      ma[i][j] = (i == j) ? 1 : 0;
      mb[i][j] = 10 * i + j - 40;
    end
    run(1'b0, -1);

    fill(3, 5);                      // R3 general case
    run(1'b0, -1);

    for (int i = 0; i < 3; i++) for (int j = 0; j < 3; j++) begin
      ma[i][j] = -128; mb[i][j] = -128;
    end
    run(1'b0, -1);                   // R8 +49152
    check(res(4) == 49152, "R8", "max positive", res(4), 49152);

    for (int i = 0; i < 3; i++) for (int j = 0; j < 3; j++) mb[i][j] = 127;
    run(1'b0, -1);                   // R8 -48768
    check(res(8) == -48768, "R8", "max negative", res(8), -48768);

    fill(7, 2);                      // R5: lanes carry junk outside windows
    run(1'b1, -1);

    // R7: junk while holding results
    begin
      automatic logic [161:0] held = c_flat;
      a_lane = 24'hFF_80_7F; b_lane = 24'h12_EE_80;
      repeat (6) @(negedge clk);
      check(done && c_flat == held, "R7", "held results", res(0), int'($signed(held[17:0])));
      a_lane = '0; b_lane = '0;
    end

    fill(11, 13);                    // R9: abandon after 3 steps, then full run
    run(1'b1, 3);
    fill(4, 9);
    run(1'b0, -1);

    check(sc_q.size() == 0, "R9", "outstanding runs", sc_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule